// File: doc/BRIEF.md
# Pipeline hazard and forwarding control

This block decides, every cycle, where the operands of a four-stage in-order integer pipeline come from and which stages may advance. The stages are fetch, decode, execute and a merged memory/write-back stage. Branch and jump targets and conditions are worked out in decode, so decode needs operand forwarding of its own. Execute needs forwarding too.

Forwarding draws only on the merged memory/write-back stage. An instruction right behind a load therefore never waits. The one exception is a control-transfer instruction in decode that reads a register the execute stage is about to produce. That instruction is held for one cycle, and a bubble goes into execute, so that the value can be forwarded from memory/write-back on the next cycle. A data bus that is not ready freezes the whole pipe. A taken redirect squashes the one instruction fetched behind it. The block is purely combinational in its outputs. Its clock and reset serve only the embedded checks.

Top module: `hzd_unit`

## Requirements
- R1: `id_fwd_a` is 1 (take the memory/write-back result) exactly when `id_rs1_used` is 1, `id_rs1` is nonzero, `mw_wr` is 1 and `mw_rd` equals `id_rs1`; otherwise it is 0 (register file). `id_fwd_b` follows the same rule with `id_rs2`/`id_rs2_used`.
- R2: `ex_fwd_a` is 1 exactly when `ex_rs1` is nonzero, `mw_wr` is 1 and `mw_rd` equals `ex_rs1`, even though the register file is written in that same cycle; the memory/write-back value, being newest, wins. `ex_fwd_b` follows the same rule with `ex_rs2`.
- R3: Register index 0 is never a forwarding source: a source index of 0 gives select 0 and never causes a stall or bubble.
- R4: With `bus_wait` = 0, when `id_is_ctl` is 1 and a used decode source (nonzero) equals `ex_rd` while `ex_wr` is 1, then `if_stall` = `id_stall` = 1, `ex_bubble` = 1, `ex_stall` = 0 and `mw_hold` = 0.
- R5: A decode instruction with `id_is_ctl` = 0 whose sources match `ex_rd` causes no stall and no bubble, since execute forwarding covers it.
- R6: `id_flush` is 1 exactly when `id_redirect` is 1, `bus_wait` is 0 and no R4 dependency stall is active.
- R7: When `bus_wait` is 1, `if_stall`, `id_stall`, `ex_stall` and `mw_hold` are all 1, and `ex_bubble` and `id_flush` are both 0, whatever the other inputs are.
- R8: A control instruction whose operands are produced only by the memory/write-back stage does not stall. Its decode selects follow R1, and with `bus_wait` = 0 and no R4 match, all stall, hold and bubble outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by embedded checks) |
| rst_n | input | 1 | Synchronous active-low reset (checks disabled while low) |
| id_rs1 | input | IDX_W | First source index of the decode instruction |
| id_rs2 | input | IDX_W | Second source index of the decode instruction |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_ctl | input | 1 | Decode instruction is a branch/jump evaluated in decode |
| id_redirect | input | 1 | Decode resolved a taken branch or a jump |
| ex_rs1 | input | IDX_W | First source index of the execute instruction |
| ex_rs2 | input | IDX_W | Second source index of the execute instruction |
| ex_rd | input | IDX_W | Destination index of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| mw_rd | input | IDX_W | Destination index of the memory/write-back instruction |
| mw_wr | input | 1 | Memory/write-back instruction writes a register |
| bus_wait | input | 1 | Data bus not ready for the current access |
| id_fwd_a | output | 1 | Decode first-operand select (1 = memory/write-back) |
| id_fwd_b | output | 1 | Decode second-operand select (1 = memory/write-back) |
| ex_fwd_a | output | 1 | Execute first-operand select (1 = memory/write-back) |
| ex_fwd_b | output | 1 | Execute second-operand select (1 = memory/write-back) |
| if_stall | output | 1 | Hold the program counter |
| id_stall | output | 1 | Hold the fetch/decode register |
| ex_stall | output | 1 | Hold the decode/execute register |
| mw_hold | output | 1 | Hold the execute/memory-write-back register |
| ex_bubble | output | 1 | Load a no-op into the decode/execute register |
| id_flush | output | 1 | Load the redirect target and squash the fetched instruction |

## Verification
The bench builds the block with `IDX_W` = 2, which gives four registers. At that width every equality and inequality among decode sources, execute sources and both destinations can be reached, and a fair share of them involve register 0. Combined with every setting of the use, control, redirect, write-enable and bus-wait flags, the sweep covers every input combination of the decode side. It covers the priority between the freeze, the dependency stall and the redirect, and tests the execute selects against a permuted reuse of the same indices.

// File: rtl/hzd_pkg.sv
// Shared definitions for the hazard and forwarding controller.
// Assumes a single forwarding source (merged memory/write-back stage).
package hzd_pkg;
    typedef enum logic {
        SRC_REGFILE = 1'b0,
        SRC_MEMWB   = 1'b1
    } opnd_src_e;

    localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/hzd_fwd_sel.sv
// Compares NOPND source indices against one producer destination and
// returns per-operand hits plus an operand-source select for each.
// Assumes index 0 is a constant-zero register and never a producer.
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned NOPND = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NOPND-1:0][IDX_W-1:0] src_idx,
    input  logic [NOPND-1:0]            src_used,
    input  logic [IDX_W-1:0]            dst_idx,
    input  logic                        dst_wr,
    output logic [NOPND-1:0]            hit,
    output opnd_src_e [NOPND-1:0]       sel
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        // Match one source against the producer, excluding register 0.
        always_comb begin
            hit[g] = src_used[g] && dst_wr
                     && (src_idx[g] == dst_idx) && (src_idx[g] != ZERO_IDX);
            sel[g] = hit[g] ? SRC_MEMWB : SRC_REGFILE;
        end

        AST_ZERO_NEVER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (dst_idx == ZERO_IDX) |-> !hit[g]); // R3
        AST_HIT_NEEDS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> (dst_wr && src_used[g])); // R1
    end
endmodule

// File: rtl/hzd_stall_ctl.sv
// Arbitrates freeze, control-dependency stall and redirect squash.
// Assumes bus_wait freezes every stage and outranks all other requests.
module hzd_stall_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_wait,
    input  logic ctl_in_id,
    input  logic ctl_dep_ex,
    input  logic redirect,
    output logic if_stall,
    output logic id_stall,
    output logic ex_stall,
    output logic mw_hold,
    output logic ex_bubble,
    output logic id_flush
);
    logic dep_stall;

    // A control instruction waits one cycle for an execute-stage producer.
    always_comb dep_stall = ctl_in_id && ctl_dep_ex;

    // Compose per-stage enables with freeze taking priority.
    always_comb begin
        if_stall  = bus_wait || dep_stall;
        id_stall  = bus_wait || dep_stall;
        ex_stall  = bus_wait;
        mw_hold   = bus_wait;
        ex_bubble = dep_stall && !bus_wait;
        id_flush  = redirect && !bus_wait && !dep_stall;
    end

    AST_BUBBLE_ONLY_WHEN_FLOWING: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> (!mw_hold && !ex_stall)); // R7
    AST_FLUSH_NOT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        id_flush |-> (!id_stall && !if_stall)); // R6
    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (if_stall && id_stall && ex_stall && mw_hold)); // R7
    AST_BUBBLE_HOLDS_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> (if_stall && id_stall)); // R4
endmodule

// File: rtl/hzd_unit.sv
// Hazard-detection and forwarding controller for a four-stage in-order
// pipeline (fetch, decode, execute, memory/write-back). Decode and execute
// operands may be taken from memory/write-back; control instructions in
// decode that need an execute result stall once. Outputs are combinational.
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] id_rs1,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic             id_rs1_used,
    input  logic             id_rs2_used,
    input  logic             id_is_ctl,
    input  logic             id_redirect,
    input  logic [IDX_W-1:0] ex_rs1,
    input  logic [IDX_W-1:0] ex_rs2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_wr,
    input  logic [IDX_W-1:0] mw_rd,
    input  logic             mw_wr,
    input  logic             bus_wait,
    output logic             id_fwd_a,
    output logic             id_fwd_b,
    output logic             ex_fwd_a,
    output logic             ex_fwd_b,
    output logic             if_stall,
    output logic             id_stall,
    output logic             ex_stall,
    output logic             mw_hold,
    output logic             ex_bubble,
    output logic             id_flush
);
    localparam int unsigned NO = NUM_OPND;

    logic [NO-1:0][IDX_W-1:0] id_src, ex_src;
    logic [NO-1:0]            id_used, ex_used;
    logic [NO-1:0]            id_hit_mw, id_hit_ex, ex_hit_mw;
    opnd_src_e [NO-1:0]       id_sel, id_sel_ex_unused, ex_sel;

    // Gather operand indices into arrays for the matchers.
    always_comb begin
        id_src  = {id_rs2, id_rs1};
        ex_src  = {ex_rs2, ex_rs1};
        id_used = {id_rs2_used, id_rs1_used};
        ex_used = '1;
    end

    hzd_fwd_sel #(.IDX_W(IDX_W), .NOPND(NO)) i_id_vs_mw (
        .clk(clk), .rst_n(rst_n),
        .src_idx(id_src), .src_used(id_used),
        .dst_idx(mw_rd), .dst_wr(mw_wr),
        .hit(id_hit_mw), .sel(id_sel)
    );

    hzd_fwd_sel #(.IDX_W(IDX_W), .NOPND(NO)) i_id_vs_ex (
        .clk(clk), .rst_n(rst_n),
        .src_idx(id_src), .src_used(id_used),
        .dst_idx(ex_rd), .dst_wr(ex_wr),
        .hit(id_hit_ex), .sel(id_sel_ex_unused)
    );

    hzd_fwd_sel #(.IDX_W(IDX_W), .NOPND(NO)) i_ex_vs_mw (
        .clk(clk), .rst_n(rst_n),
        .src_idx(ex_src), .src_used(ex_used),
        .dst_idx(mw_rd), .dst_wr(mw_wr),
        .hit(ex_hit_mw), .sel(ex_sel)
    );

    hzd_stall_ctl i_stall (
        .clk(clk), .rst_n(rst_n),
        .bus_wait(bus_wait),
        .ctl_in_id(id_is_ctl),
        .ctl_dep_ex(|id_hit_ex),
        .redirect(id_redirect),
        .if_stall(if_stall), .id_stall(id_stall),
        .ex_stall(ex_stall), .mw_hold(mw_hold),
        .ex_bubble(ex_bubble), .id_flush(id_flush)
    );

    // Drive the select ports from the matcher results.
    always_comb begin
        id_fwd_a = id_sel[0];
        id_fwd_b = id_sel[1];
        ex_fwd_a = ex_sel[0];
        ex_fwd_b = ex_sel[1];
    end

    AST_NONCTL_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_is_ctl && !bus_wait) |-> (!id_stall && !ex_bubble)); // R5
    AST_EX_FWD_MATCHES_MW: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fwd_a |-> (mw_wr && (mw_rd == ex_rs1) && (ex_rs1 != '0))); // R2
    AST_ID_FWD_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0) |-> !id_fwd_a); // R3
    AST_ID_HITS_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hit_mw[0] && id_hit_ex[0]) |-> (mw_rd == ex_rd)); // R1
    AST_EX_SEL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fwd_b == ex_hit_mw[1]); // R2
endmodule

// File: tb/test_hzd_unit.sv
// Sweeps every decode-side input combination for a 2-bit index config.
module test_hzd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mw_rd;
    logic id_rs1_used, id_rs2_used, id_is_ctl, id_redirect, ex_wr, mw_wr, bus_wait;
    logic id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b;
    logic if_stall, id_stall, ex_stall, mw_hold, ex_bubble, id_flush;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_unit #(.IDX_W(W)) i_hzd_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
        .id_is_ctl(id_is_ctl), .id_redirect(id_redirect),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wr(ex_wr),
        .mw_rd(mw_rd), .mw_wr(mw_wr), .bus_wait(bus_wait),
        .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
        .if_stall(if_stall), .id_stall(id_stall), .ex_stall(ex_stall),
        .mw_hold(mw_hold), .ex_bubble(ex_bubble), .id_flush(id_flush)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mw_rd} = '0;
        {id_rs1_used, id_rs2_used, id_is_ctl, id_redirect, ex_wr, mw_wr, bus_wait} = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset / idle state: everything from the register file, nothing held.
        chk("R7 idle", {id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b, if_stall, id_stall, ex_stall, mw_hold}, 8'h00);
        chk("R6 idle", {6'b0, ex_bubble, id_flush}, 8'h00);

        for (int v = 0; v < (1 << 15); v++) begin
            logic [14:0] b;
            logic e_ida, e_idb, e_exa, e_exb, dep, e_if, e_id, e_ex, e_mw, e_bub, e_fl;
            b = v[14:0];
            @(posedge clk);
            #1;
            id_rs1 = b[1:0]; id_rs2 = b[3:2];
            id_rs1_used = b[4]; id_rs2_used = b[5];
            id_is_ctl = b[6]; id_redirect = b[7];
            ex_rd = b[9:8]; ex_wr = b[10];
            mw_rd = b[12:11]; mw_wr = b[13];
            bus_wait = b[14];
            ex_rs1 = b[3:2]; ex_rs2 = b[1:0];
            @(negedge clk);

            e_ida = id_rs1_used && mw_wr && (mw_rd == id_rs1) && (id_rs1 != 0);
            e_idb = id_rs2_used && mw_wr && (mw_rd == id_rs2) && (id_rs2 != 0);
            e_exa = mw_wr && (mw_rd == ex_rs1) && (ex_rs1 != 0);
            e_exb = mw_wr && (mw_rd == ex_rs2) && (ex_rs2 != 0);
            dep = id_is_ctl && ex_wr &&
                  ((id_rs1_used && id_rs1 == ex_rd && id_rs1 != 0) ||
                   (id_rs2_used && id_rs2 == ex_rd && id_rs2 != 0));
            e_if  = bus_wait || dep;
            e_id  = bus_wait || dep;
            e_ex  = bus_wait;
            e_mw  = bus_wait;
            e_bub = dep && !bus_wait;
            e_fl  = id_redirect && !bus_wait && !dep;

            chk("R1 decode selects", {6'b0, id_fwd_a, id_fwd_b}, {6'b0, e_ida, e_idb});
            chk("R2 execute selects", {6'b0, ex_fwd_a, ex_fwd_b}, {6'b0, e_exa, e_exb});
            if (bus_wait)
                chk("R7 freeze", {2'b0, if_stall, id_stall, ex_stall, mw_hold, ex_bubble, id_flush},
                    {2'b0, 4'b1111, 2'b00});
            else if (dep)
                chk("R4 ctl dependency", {3'b0, if_stall, id_stall, ex_stall, mw_hold, ex_bubble},
                    {3'b0, 5'b11001});
            else if (!id_is_ctl && ex_wr && ((id_rs1 == ex_rd) || (id_rs2 == ex_rd)))
                chk("R5 no load-use stall", {4'b0, if_stall, id_stall, ex_bubble, ex_stall},
                    {4'b0, 4'b0000});
            else if (id_is_ctl && mw_wr)
                chk("R8 ctl fed from mw", {3'b0, if_stall, id_stall, ex_stall, mw_hold, ex_bubble},
                    {3'b0, 5'b00000});
            else
                chk("R4 stall outputs", {3'b0, if_stall, id_stall, ex_stall, mw_hold, ex_bubble},
                    {3'b0, e_if, e_id, e_ex, e_mw, e_bub});
            chk("R6 redirect squash", {7'b0, id_flush}, {7'b0, e_fl});
            if (id_rs1 == 0 || ex_rs1 == 0 || (ex_rd == 0 && id_is_ctl))
                chk("R3 register zero", {5'b0, (id_rs1 == 0) && id_fwd_a,
                    (ex_rs1 == 0) && ex_fwd_a, (ex_rd == 0) && !bus_wait && ex_bubble &&
                    !(ex_wr && id_is_ctl && ((id_rs2_used && id_rs2 == ex_rd && id_rs2 != 0)))},
                    8'h00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule